// File: doc/BRIEF.md
# Interrupt Acceptance Unit

This unit sits beside a processor's sequencer. It decides at which instruction boundary an interrupt is taken, and which fixed service address the program counter is loaded with. It collects five request sources:
- a non-maskable line, which is edge-detected;
- three internal exception flags (arithmetic overflow, divide by zero, undefined opcode);
- an external maskable line, which is level-sensitive.

A global disable flag gates the maskable line. The flag reads 1 while maskable requests are blocked. Separate enable and disable command strobes clear and set it.

Acceptance happens only on the end-of-instruction strobe. When a request wins, the unit first raises a push request for one cycle, asking the sequencer to save the current program counter. In the following cycle it raises the take pulse together with the winning source's fixed vector. Strobes that arrive while this two-cycle sequence is running are ignored.

Top module: `irq_accept`

## Requirements
- R1: After reset, int_disable is 1 and push_pc and take_pulse are 0.
- R2: A cmd_ei strobe clears int_disable to 0 and a cmd_di strobe sets it to 1. When both strobes arrive in the same cycle, the flag ends at 1.
- R3: While int_disable is 1, a high mask_irq is not accepted: instr_end produces no push_pc.
- R4: Nothing is accepted without instr_end. A pending request produces no push_pc until a cycle with instr_end high and the sequencer idle.
- R5: After an accepting instr_end cycle, push_pc is high for exactly the next cycle. take_pulse and vector follow in the cycle after that, and the two outputs are never high together.
- R6: Among requests pending at acceptance, the winner follows a fixed order: non-maskable first, then overflow, then divide by zero, then undefined opcode, then the maskable line.
- R7: The non-maskable request is accepted regardless of int_disable, and no command strobe can block it.
- R8: One rising edge of nmi_in yields exactly one service, even if the line stays high across later instr_end strobes.
- R9: Each exception flag pulse is held pending until that exception is taken, independent of int_disable. Taking one exception leaves the lower-priority pending exceptions in place.
- R10: The vector equals VEC_BASE + index*VEC_STRIDE, with index 0 for non-maskable, 1 for overflow, 2 for divide by zero, 3 for undefined opcode and 4 for maskable. With the defaults this gives 0x0040, 0x0048, 0x0050, 0x0058 and 0x0060.
- R11: Accepting a maskable request sets int_disable to 1, visible from the push_pc cycle onward, even if cmd_ei arrives in the same cycle.
- R12: instr_end strobes arriving during the push_pc or take_pulse cycles are ignored and start no further sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| exc_ovf | input | 1 | Overflow exception flag |
| exc_div0 | input | 1 | Divide-by-zero exception flag |
| exc_illop | input | 1 | Undefined-opcode exception flag |
| mask_irq | input | 1 | Maskable external request, level |
| cmd_ei | input | 1 | Enable-interrupt command strobe |
| cmd_di | input | 1 | Disable-interrupt command strobe |
| instr_end | input | 1 | End-of-instruction strobe |
| push_pc | output | 1 | Request to save the program counter |
| take_pulse | output | 1 | Interrupt taken; vector is valid |
| vector | output | VW | Fixed service start address |
| int_disable | output | 1 | 1 while maskable requests are blocked |

## Verification
The hardest states to reach from the ports are those where several sources are pending at once while the sequencer is busy. One example is an instr_end held high through the push and take cycles while a lower-priority exception is still waiting. Another is a non-maskable line that stays high across several instruction boundaries. The stimulus builds these states by pulsing several exception flags in one cycle before a single strobe. It then holds the strobe or the non-maskable line for extra cycles, and probes the leftover pending state with further strobes, which must yield the next vector in order or nothing.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 5;
  localparam int NEXC = 3;
  localparam int IW   = $clog2(NSRC);

  typedef enum logic [IW-1:0] {
    SRC_NMI = 3'd0,
    SRC_OVF = 3'd1,
    SRC_DIV = 3'd2,
    SRC_ILL = 3'd3,
    SRC_MSK = 3'd4
  } src_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PUSH = 2'd1,
    SQ_LOAD = 2'd2
  } seq_e;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NEXC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_in,
  input  logic [NEXC-1:0] exc_in,
  input  logic            clr_nmi,
  input  logic [NEXC-1:0] clr_exc,
  output logic            nmi_pend,
  output logic [NEXC-1:0] exc_pend
);
  logic nmi_prev;
  logic nmi_rise;

  assign nmi_rise = nmi_in & ~nmi_prev;

  // Edge-capture the non-maskable line: one rising edge makes one pending request.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_in;
      if (nmi_rise)     nmi_pend <= 1'b1;
      else if (clr_nmi) nmi_pend <= 1'b0;
    end
  end

  // One sticky pending bit per exception flag.
  // A new flag pulse wins over a clear in the same cycle.
  for (genvar g = 0; g < NEXC; g++) begin : g_exc
    always_ff @(posedge clk) begin
      if (!rst_n)          exc_pend[g] <= 1'b0;
      else if (exc_in[g])  exc_pend[g] <= 1'b1;
      else if (clr_exc[g]) exc_pend[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  // Lowest index wins: walk from the highest index down so lower ones overwrite.
  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IW'(i);
        grant = N'(1) << i;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_dflag.sv
module irq_dflag (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_ei,
  input  logic cmd_di,
  input  logic take_mask,
  output logic flag
);
  // Precedence: maskable take, then disable, then enable. Reset leaves interrupts blocked.
  always_ff @(posedge clk) begin
    if (!rst_n)                 flag <= 1'b1;
    else if (take_mask| cmd_di) flag <= 1'b1;
    else if (cmd_ei)            flag <= 1'b0;
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int VW         = 16,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 8,
  parameter int IW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_end,
  input  logic          any_req,
  input  logic [IW-1:0] win_idx,
  output logic          accept,
  output logic          push_pc,
  output logic          take_pulse,
  output logic [VW-1:0] vector
);
  import irq_pkg::*;

  seq_e          st;
  logic [VW-1:0] vec_next;

  assign vec_next = VW'(VEC_BASE + int'(win_idx) * VEC_STRIDE);
  assign accept   = (st == SQ_IDLE) && instr_end && any_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      vector <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (accept) begin
          st     <= SQ_PUSH;
          vector <= vec_next;
        end
        SQ_PUSH: st <= SQ_LOAD;
        SQ_LOAD: st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign push_pc    = (st == SQ_PUSH);
  assign take_pulse = (st == SQ_LOAD);
endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int VW         = 16,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_in,
  input  logic          exc_ovf,
  input  logic          exc_div0,
  input  logic          exc_illop,
  input  logic          mask_irq,
  input  logic          cmd_ei,
  input  logic          cmd_di,
  input  logic          instr_end,
  output logic          push_pc,
  output logic          take_pulse,
  output logic [VW-1:0] vector,
  output logic          int_disable
);
  import irq_pkg::*;

  logic            nmi_pend;
  logic [NEXC-1:0] exc_pend;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;
  logic [IW-1:0]   win_idx;
  logic            any_req;
  logic            accept;
  logic [NSRC-1:0] taken;

  irq_pending #(.NEXC(NEXC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_in  (nmi_in),
    .exc_in  ({exc_illop, exc_div0, exc_ovf}),
    .clr_nmi (taken[SRC_NMI]),
    .clr_exc (taken[NEXC:1]),
    .nmi_pend(nmi_pend),
    .exc_pend(exc_pend)
  );

  // Request vector, ordered by priority (index 0 is highest).
  assign req = {mask_irq & ~int_disable, exc_pend, nmi_pend};

  irq_prio #(.N(NSRC), .IW(IW)) u_prio (
    .req  (req),
    .any  (any_req),
    .idx  (win_idx),
    .grant(grant)
  );

  irq_seq #(
    .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE), .IW(IW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_end (instr_end),
    .any_req   (any_req),
    .win_idx   (win_idx),
    .accept    (accept),
    .push_pc   (push_pc),
    .take_pulse(take_pulse),
    .vector    (vector)
  );

  assign taken = accept ? grant : '0;

  irq_dflag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_ei   (cmd_ei),
    .cmd_di   (cmd_di),
    .take_mask(taken[SRC_MSK]),
    .flag     (int_disable)
  );
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int VW         = 16,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_end,
  input logic          cmd_di,
  input logic          push_pc,
  input logic          take_pulse,
  input logic [VW-1:0] vector,
  input logic          int_disable
);
  localparam logic [VW-1:0] VEC_MSK = VW'(VEC_BASE + 4 * VEC_STRIDE);

  // R5: take never coincides with push.
  a_r5_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_pc && take_pulse));

  // R5: take always directly follows push.
  a_r5_take_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> $past(push_pc));

  // R5: push lasts a single cycle.
  a_r5_push_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    push_pc |=> !push_pc);

  // R4: push only follows a cycle with instr_end high.
  a_r4_push_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
    push_pc |-> $past(instr_end));

  // R2: a disable strobe leaves the flag set.
  a_r2_di_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_di) |-> int_disable);

  // R11: a maskable take leaves interrupts disabled.
  a_r11_mask_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pulse && vector == VEC_MSK) |-> int_disable);
endmodule

bind irq_accept irq_accept_chk #(
  .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr_end  (instr_end),
  .cmd_di     (cmd_di),
  .push_pc    (push_pc),
  .take_pulse (take_pulse),
  .vector     (vector),
  .int_disable(int_disable)
);

// File: tb/sim_irq_accept.sv
`timescale 1ns/1ps
module sim_irq_accept;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_in = 1'b0, exc_ovf = 1'b0, exc_div0 = 1'b0, exc_illop = 1'b0;
  logic        mask_irq = 1'b0, cmd_ei = 1'b0, cmd_di = 1'b0, instr_end = 1'b0;
  logic        push_pc, take_pulse, int_disable;
  logic [15:0] vector;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_accept u0 (.*);

  // Vector table layout, 24 bits per entry:
  // [23]  enable first (otherwise disable first)
  // [22]  nmi pulse
  // [21]  overflow pulse
  // [20]  divide-by-zero pulse
  // [19]  undefined-opcode pulse
  // [18]  maskable level
  // [17]  expect a take
  // [15:0] expected vector
  localparam logic [23:0] TV [8] = '{
    {1'b1, 5'b00001, 1'b1, 1'b0, 16'h0060},  // R10 maskable
    {1'b0, 5'b00001, 1'b0, 1'b0, 16'h0000},  // R3 blocked
    {1'b1, 5'b10001, 1'b1, 1'b0, 16'h0040},  // R6 nmi over maskable
    {1'b0, 5'b01110, 1'b1, 1'b0, 16'h0048},  // R6/R9 overflow first
    {1'b0, 5'b00110, 1'b1, 1'b0, 16'h0050},  // R6 div0 over illop
    {1'b0, 5'b00010, 1'b1, 1'b0, 16'h0058},  // R10 illop
    {1'b0, 5'b10000, 1'b1, 1'b0, 16'h0040},  // R7 nmi while disabled
    {1'b1, 5'b01001, 1'b1, 1'b0, 16'h0048}   // R6 exception over maskable
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Strobe instr_end for one cycle, then sample push and take.
  // Returns whether a push occurred and the vector seen with the take.
  task automatic boundary(output bit pushed, output logic [15:0] v, output bit took);
    instr_end = 1'b1;
    tick();
    instr_end = 1'b0;
    pushed = push_pc;
    tick();
    took = take_pulse;
    v = vector;
    tick();
  endtask

  // Disable maskable requests and consume every leftover pending request.
  task automatic drain();
    bit p, t;
    logic [15:0] v;
    mask_irq = 1'b0;
    cmd_di = 1'b1;
    tick();
    cmd_di = 1'b0;
    for (int k = 0; k < 6; k++) begin
      boundary(p, v, t);
      if (!p) break;
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit p, t;
    logic [15:0] v;

    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 disable", int_disable, 1);
    check("R1 push",    push_pc,     0);
    check("R1 take",    take_pulse,  0);

    // Table walk.
    for (int i = 0; i < 8; i++) begin
      if (TV[i][23]) cmd_ei = 1'b1;
      else           cmd_di = 1'b1;
      tick();
      cmd_ei = 1'b0;
      cmd_di = 1'b0;
      nmi_in    = TV[i][22];
      exc_ovf   = TV[i][21];
      exc_div0  = TV[i][20];
      exc_illop = TV[i][19];
      tick();
      nmi_in    = 1'b0;
      exc_ovf   = 1'b0;
      exc_div0  = 1'b0;
      exc_illop = 1'b0;
      mask_irq  = TV[i][18];
      boundary(p, v, t);
      check($sformatf("R5 push entry %0d", i), p, TV[i][17]);
      check($sformatf("R5 take entry %0d", i), t, TV[i][17]);
      if (TV[i][17]) check($sformatf("R6 R10 vector entry %0d", i), v, TV[i][15:0]);
      drain();
    end

    // R2: enable alone clears the flag; both strobes together leave it set.
    cmd_ei = 1'b1;
    tick();
    cmd_ei = 1'b0;
    check("R2 ei clears", int_disable, 0);
    cmd_ei = 1'b1;
    cmd_di = 1'b1;
    tick();
    cmd_ei = 1'b0;
    cmd_di = 1'b0;
    check("R2 both sets", int_disable, 1);

    // R11: maskable take sets the flag even with a simultaneous enable.
    cmd_ei = 1'b1;
    tick();
    mask_irq  = 1'b1;
    instr_end = 1'b1;
    tick();
    cmd_ei    = 1'b0;
    instr_end = 1'b0;
    mask_irq  = 1'b0;
    check("R11 push", push_pc, 1);
    check("R11 flag set", int_disable, 1);
    tick();
    check("R11 vector", vector, 16'h0060);
    tick();
    drain();

    // R4: a pending exception waits for instr_end.
    exc_ovf = 1'b1;
    tick();
    exc_ovf = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R4 no push without end", push_pc, 0);
    end
    boundary(p, v, t);
    check("R4 accepted at end", p, 1);
    check("R9 still pending ovf", v, 16'h0048);
    drain();

    // R8: nmi held high serves once.
    nmi_in = 1'b1;
    tick();
    boundary(p, v, t);
    check("R8 first service", v, 16'h0040);
    boundary(p, v, t);
    check("R8 no second service", p, 0);
    nmi_in = 1'b0;
    drain();

    // R12: instr_end held through push and take is ignored; div0 stays pending.
    exc_ovf  = 1'b1;
    exc_div0 = 1'b1;
    tick();
    exc_ovf  = 1'b0;
    exc_div0 = 1'b0;
    instr_end = 1'b1;
    tick();
    check("R12 push", push_pc, 1);
    tick();
    check("R12 take ovf", vector, 16'h0048);
    instr_end = 1'b0;
    tick();
    check("R12 no restart", push_pc, 0);
    tick();
    check("R12 still idle", push_pc, 0);
    boundary(p, v, t);
    check("R9 div0 kept", v, 16'h0050);
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule